// File: doc/BRIEF.md
# Two-Wire Configuration Register Target with Double-Buffered Latches

This block is a target on a two-wire serial bus that gives a host access to a bank of 8-bit configuration registers. The block samples the clock line and the data line with the system clock through short synchronizer chains. It drives the data line only by pulling it low, through an output enable. A transfer opens with a start condition and an address byte. The block acknowledges the address byte only when its upper seven bits equal the fixed device address. On a write, the first byte after the address selects the register pointer. Each following byte is stored at the pointer, and the pointer then steps to the next register.

A read begins with a write that sets the pointer. The host then issues a repeated start with the direction bit set. The block sends the selected register, most significant bit first. Each time the host acknowledges a byte, the block sends the next higher register. When the host does not acknowledge a byte, the read ends and the data line is left released so that the host can issue a stop.

Written values go only into preload latches, and the datapath does not see them there. The working latches, which the datapath uses, take a copy of every preload latch while the asynchronous active-low load strobe is held low. This lets software stage a wide setting over several consecutive registers, for example a 24-bit address or a 12-bit row length such as 0x6B4. The whole setting then takes effect in one step. A path-select input hands configuration to a parallel path; while it is high, the serial target ignores all bus traffic.

Top module: `cfg_twi_target`

## Requirements
- R1: An address byte whose bits 7..1 equal DEV_ADDR (default 7'h2A) is acknowledged by holding the data line low during the ninth clock. With any other address the line stays released, and no further byte is acknowledged or stored until the next start condition.
- R2: In a write, the first byte after the address loads the pointer with its low log2(NREG) bits. Each later byte is stored in the preload latch at the pointer, is acknowledged, and advances the pointer by one, wrapping modulo NREG (default 16).
- R3: A store into a preload latch leaves the work_regs output unchanged while load_n stays high.
- R4: While load_n is low (seen after SYNC_STAGES system clocks), every working latch copies its preload latch. While load_n is high, work_regs holds its value. Register i appears at work_regs[8*i+7 : 8*i].
- R5: After a repeated start with the direction bit (bit 0 of the address byte) equal to 1, the block sends the preload latch at the pointer, most significant bit first, with bit value 0 driven as low.
- R6: When the host acknowledges a sent byte, the pointer advances by one (modulo NREG) and the next register is sent.
- R7: When the host does not acknowledge a sent byte, the transfer ends. The data line stays released for all later clocks until a new start condition.
- R8: While par_sel is high, the target drives no acknowledge and stores no byte. After par_sel returns low, the preload contents are as before.
- R9: A stop condition in the middle of a byte discards that byte. A repeated start in the middle of a write restarts address decoding, so the following pointer byte replaces the earlier pointer.
- R10: After reset, sda_oe is 0 and every working latch is 0. With par_sel low, sda_oe changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_sel | input | 1 | High hands configuration to the parallel path; the serial target ignores the bus |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low (open-drain drive) |
| load_n | input | 1 | Asynchronous active-low strobe copying preload into working latches |
| work_regs | output | 8*NREG | Working latch contents, register i in bits 8*i+7..8*i |

## Verification
The assertions assume a host that respects bus timing. The clock line changes only well apart from the data line. The data line changes only while the clock is low, except for deliberate start and stop conditions, and the host never issues a start or stop while the target holds the line. par_sel and load_n are also assumed to change slowly compared with the system clock. The stimulus meets these assumptions in a simple way. Every bus phase lasts ten system clocks, data is set up during the low half of each bit, and par_sel changes only while the bus is idle. Under these conditions the sda_oe timing property and the working-latch properties cover every transfer the bench generates.

// File: rtl/cfg_twi_pkg.sv
package cfg_twi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_RACK
   } twi_st_e;

   typedef enum logic [1:0] {
      BK_ADDR,
      BK_PTR,
      BK_DATA
   } byte_kind_e;
endpackage

// File: rtl/cfg_twi_sync.sv
module cfg_twi_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_twi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_twi_fsm.sv
module cfg_twi_fsm
   import cfg_twi_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h2A,
   parameter int         NREG     = 16,
   localparam int        PW       = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          par_sel,
   input  logic          scl_s,
   input  logic          sda_s,
   input  logic [7:0]    rd_data,
   output logic [PW-1:0] rd_idx,
   output logic          sda_oe,
   output logic          wr_en,
   output logic [PW-1:0] wr_idx,
   output logic [7:0]    wr_data
);
   twi_st_e    st;
   byte_kind_e kind;
   logic       scl_q, sda_q;
   logic [7:0] shreg, tx;
   logic [3:0] cnt;
   logic [PW-1:0] ptr;
   logic       is_rd, h_ack;

   logic scl_rise, scl_fall, start_c, stop_c;
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

   assign rd_idx = (st == ST_RACK) ? PW'(ptr + 1'b1) : ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         kind    <= BK_ADDR;
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
         shreg   <= '0;
         tx      <= '0;
         cnt     <= '0;
         ptr     <= '0;
         is_rd   <= 1'b0;
         h_ack   <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         wr_en <= 1'b0;
         if (par_sel) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_c) begin
            st     <= ST_RX;
            kind   <= BK_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     case (kind)
                        BK_ADDR: begin
                           if (shreg[7:1] == DEV_ADDR) begin
                              sda_oe <= 1'b1;
                              is_rd  <= shreg[0];
                              kind   <= BK_PTR;
                              st     <= ST_ACK;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        BK_PTR: begin
                           ptr    <= shreg[PW-1:0];
                           kind   <= BK_DATA;
                           sda_oe <= 1'b1;
                           st     <= ST_ACK;
                        end
                        default: begin
                           wr_en   <= 1'b1;
                           wr_idx  <= ptr;
                           wr_data <= shreg;
                           ptr     <= PW'(ptr + 1'b1);
                           sda_oe  <= 1'b1;
                           st      <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (is_rd) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        st     <= ST_RACK;
                     end else begin
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= ~tx[6];
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     h_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (h_ack) begin
                        ptr    <= PW'(ptr + 1'b1);
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        cnt    <= '0;
                        st     <= ST_TX;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/cfg_twi_bank.sv
module cfg_twi_bank #(
   parameter int  NREG       = 16,
   parameter bit  RD_WORKING = 1'b0,
   localparam int PW         = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_act,
   input  logic              wr_en,
   input  logic [PW-1:0]     wr_idx,
   input  logic [7:0]        wr_data,
   input  logic [PW-1:0]     rd_idx,
   output logic [7:0]        rd_data,
   output logic [NREG*8-1:0] pre_flat,
   output logic [NREG*8-1:0] work_flat
);
   logic [7:0] pre  [NREG];
   logic [7:0] work [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          pre[i] <= '0;
         else if (wr_en && wr_idx == PW'(i))  pre[i] <= wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        work[i] <= '0;
         else if (load_act) work[i] <= pre[i];
      end
      assign pre_flat[i*8 +: 8]  = pre[i];
      assign work_flat[i*8 +: 8] = work[i];
   end

   if (RD_WORKING) begin : g_rd_work
      assign rd_data = work[rd_idx];
   end else begin : g_rd_pre
      assign rd_data = pre[rd_idx];
   end
endmodule

// File: rtl/cfg_twi_target.sv
module cfg_twi_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h2A,
   parameter int         NREG        = 16,
   parameter int         SYNC_STAGES = 2,
   parameter bit         RD_WORKING  = 1'b0,
   localparam int        PW          = $clog2(NREG),
   localparam int        FLATW       = NREG * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             par_sel,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic             load_n,
   output logic [FLATW-1:0] work_regs
);
   if (NREG < 2 || NREG > 256 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("cfg_twi_target: NREG must be a power of two in 2..256");
   end

   logic scl_s, sda_s, load_s, load_act;
   logic [7:0] rd_data;
   logic [PW-1:0] rd_idx, wr_idx;
   logic wr_en;
   logic [7:0] wr_data;
   logic [FLATW-1:0] pre_flat;

   cfg_twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   cfg_twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));
   cfg_twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
      .clk(clk), .rst_n(rst_n), .d(load_n), .q(load_s));

   assign load_act = ~load_s;

   cfg_twi_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
      .clk(clk), .rst_n(rst_n), .par_sel(par_sel),
      .scl_s(scl_s), .sda_s(sda_s),
      .rd_data(rd_data), .rd_idx(rd_idx),
      .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

   cfg_twi_bank #(.NREG(NREG), .RD_WORKING(RD_WORKING)) u_bank (
      .clk(clk), .rst_n(rst_n), .load_act(load_act),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .pre_flat(pre_flat), .work_flat(work_regs));
endmodule

// File: rtl/cfg_twi_chk.sv
module cfg_twi_chk #(
   parameter int FLATW = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             par_sel,
   input logic             scl_s,
   input logic             sda_oe,
   input logic             wr_en,
   input logic             load_act,
   input logic [FLATW-1:0] pre_flat,
   input logic [FLATW-1:0] work_flat
);
   AST_PAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      par_sel |=> !sda_oe);                                          // R8
   AST_PAR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$past(par_sel));                                    // R8
   AST_STORE_NO_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !load_act) |=> $stable(work_flat));                  // R3
   AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_act |=> $stable(work_flat));                             // R4
   AST_WORK_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      load_act |=> work_flat == $past(pre_flat));                    // R4
   AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(par_sel)) |-> !scl_s);             // R10
endmodule

bind cfg_twi_target cfg_twi_chk #(.FLATW(FLATW)) u_chk (
   .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .scl_s(scl_s),
   .sda_oe(sda_oe), .wr_en(wr_en), .load_act(load_act),
   .pre_flat(pre_flat), .work_flat(work_regs));

// File: tb/tb_cfg_twi_target.sv
module tb_cfg_twi_target;
   localparam int         NREG = 16;
   localparam logic [6:0] DEV  = 7'h2A;
   localparam int         Q    = 10;
   localparam int         NV   = 6;
   // {pointer byte, data byte}
   localparam logic [15:0] VEC [NV] = '{
      16'h03A5, 16'h0F3C, 16'h0001, 16'h13C7, 16'h0880, 16'h0B6B};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic par_sel = 1'b0;
   logic scl_h = 1'b1;
   logic host_low = 1'b0;
   logic load_n = 1'b1;
   logic sda_oe;
   logic [NREG*8-1:0] work_regs;
   logic sda_line;

   assign sda_line = ~(host_low | sda_oe);

   cfg_twi_target dut (
      .clk(clk), .rst_n(rst_n), .par_sel(par_sel),
      .scl_i(scl_h), .sda_i(sda_line), .sda_oe(sda_oe),
      .load_n(load_n), .work_regs(work_regs));

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int r10_viol = 0;
   bit done = 1'b0;
   logic [7:0] pre_m  [NREG];
   logic [7:0] work_m [NREG];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      host_low = 1'b0; scl_h = 1'b1; qwait();
      host_low = 1'b1; qwait();
      scl_h = 1'b0; qwait();
   endtask

   task automatic bus_rstart();
      host_low = 1'b0; qwait();
      scl_h = 1'b1; qwait();
      host_low = 1'b1; qwait();
      scl_h = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      host_low = 1'b1; qwait();
      scl_h = 1'b1; qwait();
      host_low = 1'b0; qwait();
   endtask

   task automatic send_bit(input logic b);
      host_low = ~b; qwait();
      scl_h = 1'b1; qwait(); qwait();
      scl_h = 1'b0; qwait();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      host_low = 1'b0; qwait();
      scl_h = 1'b1; qwait();
      acked = (sda_line == 1'b0);
      qwait();
      scl_h = 1'b0; qwait();
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      host_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         qwait();
         scl_h = 1'b1; qwait();
         b[i] = sda_line;
         qwait();
         scl_h = 1'b0;
      end
      host_low = give_ack; qwait();
      scl_h = 1'b1; qwait(); qwait();
      scl_h = 1'b0; qwait();
      host_low = 1'b0;
   endtask

   task automatic write_seq(input logic [7:0] p, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R1 address ack on write", 32'(a), 1);
      send_byte(p, a);           chk("R2 pointer byte ack", 32'(a), 1);
      for (int k = 0; k < n; k++) begin
         d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
         send_byte(d, a);
         chk("R2 data byte ack", 32'(a), 1);
         pre_m[(32'(p) + k) % NREG] = d;
      end
      bus_stop();
   endtask

   task automatic read_check(input logic [7:0] p, input int n, input bit check_release);
      logic a;
      logic [7:0] b;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(p, a);
      bus_rstart();
      send_byte({DEV, 1'b1}, a); chk("R5 address ack on read", 32'(a), 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, b);
         if (k == 0) chk("R5 first read byte", 32'(b), 32'(pre_m[32'(p) % NREG]));
         else        chk("R6 next read byte", 32'(b), 32'(pre_m[(32'(p) + k) % NREG]));
      end
      if (check_release) begin
         // R7: after the host's no-acknowledge the line must stay high
         logic low_seen;
         low_seen = 1'b0;
         for (int i = 0; i < 9; i++) begin
            qwait(); scl_h = 1'b1; qwait();
            if (sda_line == 1'b0) low_seen = 1'b1;
            qwait(); scl_h = 1'b0;
         end
         qwait();
         chk("R7 line released after no-ack", 32'(low_seen), 0);
      end
      bus_stop();
   endtask

   task automatic check_work(input string tag);
      for (int i = 0; i < NREG; i++)
         chk(tag, 32'(work_regs[i*8 +: 8]), 32'(work_m[i]));
   endtask

   task automatic pulse_load();
      @(negedge clk); load_n = 1'b0;
      repeat (5) @(negedge clk);
      load_n = 1'b1;
      repeat (5) @(negedge clk);
      for (int i = 0; i < NREG; i++) work_m[i] = pre_m[i];
   endtask

   // R10 monitor: sda_oe may change only while the bus clock is low
   logic oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !par_sel && sda_oe !== oe_prev && scl_h === 1'b1) r10_viol++;
      oe_prev = sda_oe;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic a;
      for (int i = 0; i < NREG; i++) begin pre_m[i] = '0; work_m[i] = '0; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10 reset sda_oe", 32'(sda_oe), 0);
      check_work("R10 reset working latches");

      // table walk: single write then read back (R2 wrap on pointer 0x13)
      for (int v = 0; v < NV; v++) begin
         write_seq(VEC[v][15:8], 1, VEC[v][7:0], 8'h00, 8'h00);
         read_check(VEC[v][15:8], 1, 1'b0);
         check_work("R3 working unchanged after store");
      end

      pulse_load();
      check_work("R4 working copies preload");

      // multi-byte write across the top, wrapping to register 0
      write_seq(8'h0E, 3, 8'h11, 8'h22, 8'h33);
      check_work("R3 working held without load");
      read_check(8'h0E, 3, 1'b1);
      pulse_load();
      check_work("R4 second load");

      // R1: wrong address is ignored
      bus_start();
      send_byte({7'h2B, 1'b0}, a); chk("R1 no ack on other address", 32'(a), 0);
      send_byte(8'h05, a);         chk("R1 no ack after mismatch", 32'(a), 0);
      send_byte(8'hEE, a);         chk("R1 no ack on data after mismatch", 32'(a), 0);
      bus_stop();
      read_check(8'h05, 1, 1'b0);

      // R8: parallel path selected
      par_sel = 1'b1; qwait();
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R8 no ack while parallel", 32'(a), 0);
      send_byte(8'h03, a);
      send_byte(8'h99, a);       chk("R8 no data ack while parallel", 32'(a), 0);
      bus_stop();
      par_sel = 1'b0; qwait();
      read_check(8'h03, 1, 1'b0);

      // R9: stop in the middle of a data byte discards it
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h07, a);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      bus_stop();
      read_check(8'h07, 1, 1'b0);

      // R9: repeated start inside a write restarts decoding
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h09, a);
      bus_rstart();
      send_byte({DEV, 1'b0}, a); chk("R9 ack after repeated start", 32'(a), 1);
      send_byte(8'h0A, a);
      send_byte(8'h77, a);
      pre_m[10] = 8'h77;
      bus_stop();
      read_check(8'h09, 2, 1'b0);

      chk("R10 sda_oe changed only with clock low", 32'(r10_viol), 0);
      check_work("R4 working held after traffic");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule